// File: doc/BRIEF.md
# Systolic Montgomery Modular Multiplier

This block multiplies two residues in the Montgomery domain. Given operands A and B and an odd modulus N, all smaller than R^k with R = 2^16 and k the number of active 16-bit digits, it returns A·B·R^(-k) mod N. A host streams the three numbers in together, one digit of each per beat, least significant digit first. The host also supplies the digit count and the constant ninv = −N^(-1) mod 2^16. It then collects the result as a stream of k digits, least significant first.

The datapath is a chain of identical processing elements, one for each digit position. Each clock performs one iteration of the add-shift recurrence: it adds a_i·B and q·N to the running sum. Each element forwards the low half of its local sum to the element below it, and that backward hand-over is the division by the radix. The high half stays in the element's own carry register, so carries advance one digit position per clock relative to the sum. When all iterations are done, a serial pass folds the carries into plain digits. The same pass computes the sum minus N, and the smaller valid value is streamed out. The digit count is set per job, up to a build-time maximum, so one kernel serves several precisions.

Top module: `mm_systolic_mul`

## Requirements
- R1: `in_ready` is high after reset and while operands are being loaded. It goes low at the edge that accepts the final operand beat. It stays low until the clock edge that follows the one-cycle `done` pulse.
- R2: `cfg_digits` and `cfg_ninv` are sampled only with the first operand beat of a job. A count from 1 to MAXD is used as given, and a count of 0 or above MAXD means MAXD.
- R3: For odd N with A, B < N < R^k, the k emitted digits form A·B·R^(-k) mod N, where R = 2^16.
- R4: The emitted result is always below N: when the folded sum reaches N, N is subtracted exactly once.
- R5: `out_valid` rises 2k+1 clock edges after the edge that accepts the final operand beat. Digits leave least significant first, one per `out_valid && out_ready` handshake. While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R6: `out_last` is high together with `out_valid` on the k-th digit only.
- R7: `done` is a single-cycle pulse in the cycle after the handshake that carries the final digit.
- R8: Operand digits at positions k and above that were loaded by an earlier, longer job have no effect on the result.
- R9: While reset is asserted, `in_ready` is 1, `out_valid` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_digits | input | $clog2(MAXD+1) | Active digit count, sampled with the first beat |
| cfg_ninv | input | W | −N^(-1) mod 2^W, sampled with the first beat |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block accepts operand beats |
| in_a | input | W | Digit of A |
| in_b | input | W | Digit of B |
| in_n | input | W | Digit of N |
| out_valid | output | 1 | Result digit present |
| out_ready | input | 1 | Host accepts the result digit |
| out_data | output | W | Result digit |
| out_last | output | 1 | Marks the most significant result digit |
| done | output | 1 | One-cycle pulse after the last digit leaves |

## Verification
The bench builds the block with W = 16 and MAXD = 8. This covers the 64-bit (k = 4) and 128-bit (k = 8) precisions, the single-digit case, and the clamped counts 0 and 12. Because MAXD is 8, a 128-bit job can be followed by a shorter job, which exposes stale upper digits. Moduli of all ones are applied together with operands equal to N−1. With the subtraction branch taken on some jobs and skipped on others, both outcomes of the final compare occur, and gaps on the input and stalls on the output exercise the handshakes.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int DIG_W = 16;

  typedef enum logic [1:0] {T_IDLE, T_LOAD, T_MUL, T_FIN} top_st_e;
  typedef enum logic [1:0] {F_IDLE, F_RES, F_OUT} fin_st_e;
endpackage

// File: rtl/mm_pe.sv
// One digit slice: sum digit moves down the chain, carry stays local.
module mm_pe #(
  parameter int W = 16,
  localparam int CW = W + 3,
  localparam int TW = 2 * W + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [W-1:0]  a_dig,
  input  logic [W-1:0]  q_dig,
  input  logic [W-1:0]  b_dig,
  input  logic [W-1:0]  n_dig,
  input  logic [W-1:0]  lo_in,
  output logic [W-1:0]  s_q,
  output logic [CW-1:0] c_q,
  output logic [W-1:0]  lo_out
);
  logic [2*W-1:0] prod_ab;
  logic [2*W-1:0] prod_qn;
  logic [TW-1:0]  tsum;

  assign prod_ab = a_dig * b_dig;
  assign prod_qn = q_dig * n_dig;
  assign tsum    = TW'(s_q) + TW'(c_q) + TW'(prod_ab) + TW'(prod_qn);
  assign lo_out  = tsum[W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      s_q <= '0;
      c_q <= '0;
    end else if (step) begin
      s_q <= lo_in;            // divide by radix: neighbour above hands its digit down
      c_q <= tsum[TW-1:W];
    end
  end
endmodule

// File: rtl/mm_array.sv
// Chain of MAXD+1 slices plus the quotient digit logic.
module mm_array #(
  parameter int W    = 16,
  parameter int MAXD = 8,
  localparam int CW  = W + 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     step,
  input  logic [W-1:0]             a_dig,
  input  logic [W-1:0]             ninv,
  input  logic [MAXD:0][W-1:0]     b_vec,
  input  logic [MAXD:0][W-1:0]     n_vec,
  output logic [MAXD:0][W-1:0]     s_vec,
  output logic [MAXD:0][CW-1:0]    c_vec,
  output logic [W-1:0]             drop_dig
);
  logic [W-1:0] ab_low;
  logic [W-1:0] low_sum;
  logic [W-1:0] q_dig;
  logic [W-1:0] lo_w [0:MAXD];

  // q makes the bottom digit of the iteration sum vanish (R3)
  assign ab_low  = a_dig * b_vec[0];
  assign low_sum = s_vec[0] + c_vec[0][W-1:0] + ab_low;
  assign q_dig   = low_sum * ninv;

  for (genvar j = 0; j <= MAXD; j++) begin : g_pe
    logic [W-1:0] lo_from_above;
    if (j == MAXD) begin : g_top
      assign lo_from_above = '0;
    end else begin : g_mid
      assign lo_from_above = lo_w[j+1];
    end
    mm_pe #(.W(W)) u_pe (
      .clk    (clk),
      .rst    (rst),
      .clear  (clear),
      .step   (step),
      .a_dig  (a_dig),
      .q_dig  (q_dig),
      .b_dig  (b_vec[j]),
      .n_dig  (n_vec[j]),
      .lo_in  (lo_from_above),
      .s_q    (s_vec[j]),
      .c_q    (c_vec[j]),
      .lo_out (lo_w[j])
    );
  end

  assign drop_dig = lo_w[0];
endmodule

// File: rtl/mm_finish.sv
// Serial carry fold, trial subtraction of N, and result streaming.
module mm_finish #(
  parameter int W    = 16,
  parameter int MAXD = 8,
  localparam int CW  = W + 3,
  localparam int DW  = $clog2(MAXD + 1),
  localparam int AW  = $clog2(MAXD)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [DW-1:0]         k,
  input  logic [MAXD:0][W-1:0]  s_vec,
  input  logic [MAXD:0][CW-1:0] c_vec,
  input  logic [MAXD:0][W-1:0]  n_vec,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [W-1:0]          out_data,
  output logic                  out_last,
  output logic                  done
);
  import mm_pkg::*;

  fin_st_e             ph_q;
  logic [DW-1:0]       idx_q;
  logic [DW-1:0]       ptr_q;
  logic [DW-1:0]       ptr_nx;
  logic [CW-1:0]       cy_q;
  logic                bw_q;
  logic                use_dif_q;
  logic [MAXD-1:0][W-1:0] res_q;
  logic [MAXD-1:0][W-1:0] dif_q;

  logic [CW:0]  fold;
  logic [W-1:0] rdig;
  logic [W:0]   dsub;
  logic         at_top;

  assign fold   = (CW+1)'(s_vec[idx_q]) + (CW+1)'(c_vec[idx_q]) + (CW+1)'(cy_q);
  assign rdig   = fold[W-1:0];
  assign dsub   = {1'b0, rdig} - {1'b0, n_vec[idx_q]} - {{W{1'b0}}, bw_q};
  assign at_top = (idx_q == k);
  assign ptr_nx = ptr_q + DW'(1);

  // digit stores: no reset, written once per job
  always_ff @(posedge clk) begin
    if (ph_q == F_RES && !at_top) begin
      res_q[AW'(idx_q)] <= rdig;
      dif_q[AW'(idx_q)] <= dsub[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= F_IDLE;
      idx_q     <= '0;
      ptr_q     <= '0;
      cy_q      <= '0;
      bw_q      <= 1'b0;
      use_dif_q <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph_q)
        F_IDLE: begin
          if (start) begin
            ph_q  <= F_RES;
            idx_q <= '0;
            cy_q  <= '0;
            bw_q  <= 1'b0;
          end
        end
        F_RES: begin
          if (at_top) begin
            // borrow out of the top position means the sum is below N (R4)
            use_dif_q <= ~dsub[W];
            out_data  <= dsub[W] ? res_q[0] : dif_q[0];
            out_last  <= (k == DW'(1));
            out_valid <= 1'b1;
            ptr_q     <= '0;
            ph_q      <= F_OUT;
          end else begin
            cy_q  <= CW'(fold[CW:W]);
            bw_q  <= dsub[W];
            idx_q <= idx_q + DW'(1);
          end
        end
        F_OUT: begin
          if (out_ready) begin
            if (out_last) begin
              out_valid <= 1'b0;
              out_last  <= 1'b0;
              done      <= 1'b1;      // R7
              ph_q      <= F_IDLE;
            end else begin
              ptr_q    <= ptr_nx;
              out_data <= use_dif_q ? dif_q[AW'(ptr_nx)] : res_q[AW'(ptr_nx)];
              out_last <= (ptr_q + DW'(2) == k);
            end
          end
        end
        default: ph_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mm_systolic_mul.sv
// Top: operand loading, iteration control, array and finishing stage.
module mm_systolic_mul #(
  parameter int W    = mm_pkg::DIG_W,
  parameter int MAXD = 8,
  localparam int DW  = $clog2(MAXD + 1),
  localparam int AW  = $clog2(MAXD),
  localparam int CW  = W + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cfg_digits,
  input  logic [W-1:0]  cfg_ninv,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [W-1:0]  in_n,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_last,
  output logic          done
);
  import mm_pkg::*;

  localparam logic [DW-1:0] MAXD_D = DW'(MAXD);

  top_st_e       st_q;
  logic [DW-1:0] nd_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] iter_q;
  logic [W-1:0]  ninv_q;
  logic [MAXD-1:0][W-1:0] a_q;
  logic [MAXD-1:0][W-1:0] b_q;
  logic [MAXD-1:0][W-1:0] n_q;

  logic [DW-1:0] cfg_eff;
  logic [DW-1:0] cur_nd;
  logic [DW-1:0] cnt_idx;
  logic          fire_in;
  logic          last_beat;
  logic          ar_step;
  logic          fin_start;
  logic [W-1:0]  pe0_drop;
  logic [MAXD:0][W-1:0]  b_full;
  logic [MAXD:0][W-1:0]  n_full;
  logic [MAXD:0][W-1:0]  s_vec;
  logic [MAXD:0][CW-1:0] c_vec;

  // R2: out-of-range counts select the full width
  assign cfg_eff   = (cfg_digits == '0 || cfg_digits > MAXD_D) ? MAXD_D : cfg_digits;
  assign cur_nd    = (st_q == T_IDLE) ? cfg_eff : nd_q;
  assign cnt_idx   = (st_q == T_IDLE) ? '0 : cnt_q;
  assign in_ready  = (st_q == T_IDLE) || (st_q == T_LOAD);
  assign fire_in   = in_valid && in_ready;
  assign last_beat = fire_in && (cnt_idx == cur_nd - DW'(1));
  assign ar_step   = (st_q == T_MUL);
  assign fin_start = ar_step && (iter_q == nd_q - DW'(1));
  assign b_full    = {W'(0), b_q};
  assign n_full    = {W'(0), n_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= T_IDLE;
      nd_q   <= '0;
      cnt_q  <= '0;
      iter_q <= '0;
      ninv_q <= '0;
    end else begin
      case (st_q)
        T_IDLE: begin
          if (fire_in) begin
            nd_q   <= cfg_eff;
            ninv_q <= cfg_ninv;
            cnt_q  <= DW'(1);
            iter_q <= '0;
            st_q   <= last_beat ? T_MUL : T_LOAD;
          end
        end
        T_LOAD: begin
          if (fire_in) begin
            cnt_q <= cnt_q + DW'(1);
            if (last_beat) st_q <= T_MUL;
          end
        end
        T_MUL: begin
          iter_q <= iter_q + DW'(1);
          if (fin_start) st_q <= T_FIN;
        end
        T_FIN: begin
          if (done) st_q <= T_IDLE;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  // R8: the first beat of a job zeroes every higher B and N digit
  always_ff @(posedge clk) begin
    if (fire_in) begin
      for (int j = 0; j < MAXD; j++) begin
        if (DW'(j) == cnt_idx) begin
          a_q[j] <= in_a;
          b_q[j] <= in_b;
          n_q[j] <= in_n;
        end else if (st_q == T_IDLE) begin
          b_q[j] <= '0;
          n_q[j] <= '0;
        end
      end
    end
  end

  mm_array #(.W(W), .MAXD(MAXD)) u_arr (
    .clk      (clk),
    .rst      (rst),
    .clear    (last_beat),
    .step     (ar_step),
    .a_dig    (a_q[AW'(iter_q)]),
    .ninv     (ninv_q),
    .b_vec    (b_full),
    .n_vec    (n_full),
    .s_vec    (s_vec),
    .c_vec    (c_vec),
    .drop_dig (pe0_drop)
  );

  mm_finish #(.W(W), .MAXD(MAXD)) u_fin (
    .clk       (clk),
    .rst       (rst),
    .start     (fin_start),
    .k         (nd_q),
    .s_vec     (s_vec),
    .c_vec     (c_vec),
    .n_vec     (n_full),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .done      (done)
  );
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_last,
  input logic         done,
  input logic         ar_step,
  input logic [W-1:0] pe0_drop
);
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r6_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_after_final: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_ready && out_last));

  a_r1_ready_exclusive: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid && !done);

  a_r3_bottom_digit_zero: assert property (@(posedge clk) disable iff (rst)
    ar_step |-> pe0_drop == '0);
endmodule

bind mm_systolic_mul mm_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .done      (done),
  .ar_step   (ar_step),
  .pe0_drop  (pe0_drop)
);

// File: tb/mm_systolic_mul_bench.sv
module mm_systolic_mul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int MAXD = 8;
  localparam int DW   = $clog2(MAXD + 1);
  localparam int BIG  = W * MAXD;

  logic          clk = 1'b0;
  logic          rst;
  logic [DW-1:0] cfg_digits;
  logic [W-1:0]  cfg_ninv;
  logic          in_valid, in_ready;
  logic [W-1:0]  in_a, in_b, in_n;
  logic          out_valid, out_ready, out_last, done;
  logic [W-1:0]  out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_systolic_mul #(.W(W), .MAXD(MAXD)) u_mm_systolic_mul (
    .clk(clk), .rst(rst), .cfg_digits(cfg_digits), .cfg_ninv(cfg_ninv),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b), .in_n(in_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(bit ok, string tag, logic [BIG-1:0] act, logic [BIG-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural big-integer reference
  function automatic logic [BIG-1:0] mont_ref(logic [BIG-1:0] a, logic [BIG-1:0] b,
                                              logic [BIG-1:0] n, int k);
    logic [2*BIG-1:0] p;
    p = ((2*BIG)'(a) * (2*BIG)'(b)) % (2*BIG)'(n);
    for (int i = 0; i < W * k; i++)
      p = p[0] ? (p + (2*BIG)'(n)) >> 1 : p >> 1;
    return p[BIG-1:0];
  endfunction

  function automatic logic [W-1:0] ninv_of(logic [W-1:0] n0);
    logic [W-1:0] inv;
    inv = n0;
    for (int i = 0; i < 5; i++) inv = inv * (W'(2) - n0 * inv);
    return -inv;
  endfunction

  function automatic logic [BIG-1:0] rand_bits(int nbits);
    logic [BIG-1:0] v;
    logic [BIG-1:0] mask;
    for (int i = 0; i < BIG / 32; i++) v[32*i +: 32] = $urandom;
    mask = (nbits >= BIG) ? '1 : ((BIG'(1) << nbits) - BIG'(1));
    return v & mask;
  endfunction

  // job and model state
  logic [BIG-1:0] j_a, j_b, j_n, j_exp, j_got;
  logic [DW-1:0]  j_kcfg;
  logic [W-1:0]   j_ninv;
  int j_k = 0, j_si = 0;
  bit j_stall, j_gap, j_finished;
  int m_st = 0, m_cnt = 0, m_wait = 0, m_ptr = 0;
  bit m_done = 1'b0;

  task automatic tick();
    bit fire_in, fire_out;
    // compare every output against the model (sampled at the falling edge)
    check(in_ready == (m_st == 0 || m_st == 1), "R1 in_ready", BIG'(in_ready), BIG'(m_st < 2));
    check(out_valid == (m_st == 3), "R5 out_valid", BIG'(out_valid), BIG'(m_st == 3));
    check(done == m_done, "R7 done pulse", BIG'(done), BIG'(m_done));
    if (m_st == 3) begin
      check(out_data == j_exp[W*m_ptr +: W], "R3 result digit", BIG'(out_data), BIG'(j_exp[W*m_ptr +: W]));
      check(out_last == (m_ptr == j_k - 1), "R6 out_last", BIG'(out_last), BIG'(m_ptr == j_k - 1));
    end
    // drive inputs for the coming edge
    if ((m_st == 0 || m_st == 1) && j_si < j_k && (!j_gap || $urandom_range(0, 2) != 0)) begin
      in_valid = 1'b1;
      in_a = j_a[W*j_si +: W];
      in_b = j_b[W*j_si +: W];
      in_n = j_n[W*j_si +: W];
    end else begin
      in_valid = 1'b0;
      in_a = W'($urandom); in_b = W'($urandom); in_n = W'($urandom);
    end
    if (m_st == 0) begin
      cfg_digits = j_kcfg;
      cfg_ninv   = j_ninv;
    end else begin
      cfg_digits = DW'($urandom);   // R2: ignored after the first beat
      cfg_ninv   = W'($urandom);
    end
    out_ready = !j_stall || ($urandom_range(0, 1) == 1);
    // advance the model by one edge
    fire_in  = in_valid && (m_st == 0 || m_st == 1);
    fire_out = out_ready && (m_st == 3);
    case (m_st)
      0: if (fire_in) begin
           j_si++; m_cnt = 1;
           if (j_k == 1) begin m_st = 2; m_wait = 2 * j_k + 1; end else m_st = 1;
         end
      1: if (fire_in) begin
           j_si++; m_cnt++;
           if (m_cnt == j_k) begin m_st = 2; m_wait = 2 * j_k + 1; end
         end
      2: begin
           m_wait--;
           if (m_wait == 0) begin m_st = 3; m_ptr = 0; end
         end
      3: if (fire_out) begin
           j_got[W*m_ptr +: W] = out_data;
           if (m_ptr == j_k - 1) begin m_st = 4; m_done = 1'b1; end
           else m_ptr++;
         end
      default: begin m_st = 0; m_done = 1'b0; j_finished = 1'b1; end
    endcase
    @(negedge clk);
  endtask

  task automatic run_job(logic [BIG-1:0] a, logic [BIG-1:0] b, logic [BIG-1:0] n,
                         int kcfg, bit stall, bit gap, string tag);
    int guard;
    j_a = a; j_b = b; j_n = n;
    j_kcfg = DW'(kcfg);
    j_k = (kcfg == 0 || kcfg > MAXD) ? MAXD : kcfg;
    j_ninv = ninv_of(n[W-1:0]);
    j_exp = mont_ref(a, b, n, j_k);
    j_got = '0; j_si = 0; j_finished = 1'b0;
    j_stall = stall; j_gap = gap;
    guard = 0;
    while (!j_finished && guard < 4000) begin
      tick();
      guard++;
    end
    if (!j_finished) check(1'b0, "R5 job watchdog", BIG'(guard), '0);
    check(j_got == j_exp, tag, j_got, j_exp);
    check(j_got < n, "R4 below modulus", j_got, n);
  endtask

  task automatic run_random(int k, bit stall, bit gap, string tag);
    logic [BIG-1:0] n;
    n = rand_bits(W * k);
    n[0] = 1'b1;
    if (n < 3) n = 3;
    run_job(rand_bits(BIG) % n, rand_bits(BIG) % n, n, k, stall, gap, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [BIG-1:0] nmax;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    in_a = '0; in_b = '0; in_n = '0; cfg_digits = '0; cfg_ninv = '0;
    j_kcfg = '0; j_ninv = '0; j_stall = 1'b0; j_gap = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R9 reset in_ready", BIG'(in_ready), BIG'(1));
    check(out_valid == 1'b0, "R9 reset out_valid", BIG'(out_valid), '0);
    check(done == 1'b0, "R9 reset done", BIG'(done), '0);
    rst = 1'b0;

    run_random(1, 1'b0, 1'b0, "R3 single digit");
    for (int i = 0; i < 10; i++) run_random(4, 1'b0, 1'b0, "R3 64-bit");
    for (int i = 0; i < 10; i++) run_random(8, 1'b1, 1'b1, "R3 128-bit with stalls");
    for (int i = 2; i < 8; i++) run_random(i, 1'b1, 1'b0, "R3 mixed width");
    run_random(0, 1'b0, 1'b1, "R2 count zero means MAXD");
    run_random(12, 1'b1, 1'b0, "R2 count above MAXD");

    // zero operand and largest operands
    nmax = rand_bits(W * 4); nmax[0] = 1'b1;
    run_job('0, nmax - 1, nmax, 4, 1'b0, 1'b0, "R3 zero operand");
    nmax = (BIG'(1) << (W * 4)) - 1;
    run_job(nmax - 1, nmax - 1, nmax, 4, 1'b1, 1'b0, "R4 all-ones modulus");
    nmax = '1;
    run_job(nmax - 1, nmax - 1, nmax, 8, 1'b0, 1'b1, "R4 all-ones 128-bit");

    // long job leaves high digits behind, short job must ignore them
    for (int i = 0; i < 4; i++) begin
      run_random(8, 1'b0, 1'b0, "R3 128-bit before short");
      run_random(2 + i, 1'b1, 1'b1, "R8 stale upper digits");
    end
    for (int i = 0; i < 10; i++) run_random(1 + (i % MAXD), 1'b1, 1'b1, "R5 handshake mix");

    repeat (3) tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule